// File: doc/BRIEF.md
# Load/Store Data Watchpoint Comparator

This block observes the memory accesses of a 32-bit processor and flags a watchpoint when an address condition and a data condition hold together. Each access arrives with its address, size, direction and data on a 32-bit byte-laned bus. Two address comparators can each be set to equal, not-equal, greater-or-equal or less-than. They can be joined with AND to form a window. A per-lane enable selects which byte lanes of the data comparator take part. This lets a byte or half-word value be found even when a wider load or store moves it.

The address comparison adapts to the access size. For a word access the two lowest address bits are ignored on both the access and the programmed side. For a half-word access the lowest bit is ignored. A match is only remembered while the owning instruction is in flight. The event is reported when that instruction retires, at most once per instruction, and a pipeline flush discards it. A down-counter, loaded by the user, steps on each reported event and raises a terminal flag at zero.

Top module: `lsw_data_watch`

## Requirements
- R1: After reset `wp_event` is 0, `cnt_value` is 0 and `cnt_zero` is 1.
- R2: For a word access (`acc_size`=2'b10) address bits [1:0] of both the access and the compare address are ignored.
- R3: For a half-word access (`acc_size`=2'b01) address bit 0 of both sides is ignored; for a byte access (`acc_size`=2'b00) every address bit is compared.
- R4: Each address comparator applies the operation selected by its 2-bit code (0 equal, 1 not-equal, 2 unsigned greater-or-equal, 3 unsigned less-than) to the size-masked addresses; with `range_en`=1 the address condition is comparator A AND comparator B, otherwise comparator A alone.
- R5: Byte lane i of the data bus is bits [8i+7:8i]; `lane_en[i]`=1 puts lane i in the data compare. With `data_neq`=0 the data condition holds when every enabled lane equals `cmp_data`; with `data_neq`=1 it holds when at least one enabled lane differs. Disabled lanes always count as equal.
- R6: `dir_sel` gates the match: 0 any access, 1 reads only (`acc_write`=0), 2 writes only, 3 no access matches.
- R7: A match is reported as a one-cycle `wp_event` in the cycle after the cycle where `instr_retire` is high. Matches in the retire cycle itself belong to the retiring instruction, and any number of matches inside one instruction give exactly one event.
- R8: `flush` discards any remembered match. A flush in the retire cycle suppresses that instruction's event.
- R9: `cnt_load` loads `cnt_init` into the counter at the next edge. Each reported event lowers the counter by exactly one.
- R10: `cnt_zero` is 1 exactly when the counter is 0. The counter stays at 0 on further events, and a load in the same cycle as an event takes priority.
- R11: The reserved size code 2'b11 is compared as a word access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| acc_valid | input | 1 | A load/store transfer is present this cycle |
| acc_addr | input | AW | Transfer byte address |
| acc_size | input | 2 | 00 byte, 01 half-word, 10 word, 11 treated as word |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_data | input | DW | Transfer data, byte-laned |
| instr_retire | input | 1 | The instruction owning current transfers retires this cycle |
| flush | input | 1 | Pipeline flush, drops the in-flight instruction |
| cmp_addr_a | input | AW | Compare address of comparator A |
| cmp_addr_b | input | AW | Compare address of comparator B |
| addr_op_a | input | 2 | Operation code of comparator A |
| addr_op_b | input | 2 | Operation code of comparator B |
| range_en | input | 1 | Combine comparators A and B with AND |
| cmp_data | input | DW | Data match value, placed in the chosen lanes |
| lane_en | input | DW/8 | Per-byte-lane participation in the data compare |
| data_neq | input | 1 | 0 equal, 1 not-equal data condition |
| dir_sel | input | 2 | Direction qualifier |
| cnt_load | input | 1 | Load the event counter |
| cnt_init | input | CW | Value loaded into the counter |
| wp_event | output | 1 | One pulse per retired instruction that matched |
| cnt_value | output | CW | Event counter |
| cnt_zero | output | 1 | Counter has reached zero |

## Verification
The bench builds the block with 32-bit address and data and a 6-bit counter. The narrow counter lets short load values drive it to zero, into saturation and into the load-versus-event collision within a few instructions. A 32-bit data bus gives four lanes, so single-lane, two-lane and all-lanes-off masks are all exercised against word, half-word and byte transfers. A behavioural model follows every clock through directed scenarios and a long random phase. That phase mixes the four address operations, range mode, flushes and multi-transfer instructions close to the programmed addresses.

// File: rtl/lsw_pkg.sv
package lsw_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

  typedef enum logic [1:0] {
    AOP_EQ = 2'd0,
    AOP_NE = 2'd1,
    AOP_GE = 2'd2,
    AOP_LT = 2'd3
  } addr_op_e;

  typedef enum logic [1:0] {
    DIR_ANY   = 2'd0,
    DIR_READ  = 2'd1,
    DIR_WRITE = 2'd2,
    DIR_OFF   = 2'd3
  } dir_sel_e;

  // Low address bits that still take part in the compare, per access size.
  function automatic logic [1:0] keep_low_bits(input logic [1:0] size);
    logic [1:0] keep;
    case (acc_size_e'(size))
      SZ_BYTE: keep = 2'b11;
      SZ_HALF: keep = 2'b10;
      default: keep = 2'b00;
    endcase
    return keep;
  endfunction

endpackage

// File: rtl/lsw_addr_cmp.sv
module lsw_addr_cmp
  import lsw_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [1:0]    size,
  input  logic [AW-1:0] ref_addr,
  input  logic [1:0]    op,
  output logic          hit
);

  logic [1:0]    keep;
  logic [AW-1:0] addr_m;
  logic [AW-1:0] ref_m;

  always_comb begin
    keep   = keep_low_bits(size);
    addr_m = {addr[AW-1:2], addr[1:0] & keep};
    ref_m  = {ref_addr[AW-1:2], ref_addr[1:0] & keep};
  end

  always_comb begin
    case (addr_op_e'(op))
      AOP_EQ:  hit = (addr_m == ref_m);
      AOP_NE:  hit = (addr_m != ref_m);
      AOP_GE:  hit = (addr_m >= ref_m);
      default: hit = (addr_m <  ref_m);
    endcase
  end

endmodule

// File: rtl/lsw_data_cmp.sv
module lsw_data_cmp #(
  parameter int DW = 32,
  localparam int LANES = DW / 8
) (
  input  logic [DW-1:0]    data,
  input  logic [DW-1:0]    ref_data,
  input  logic [LANES-1:0] lane_en,
  input  logic             neq,
  output logic             hit
);

  logic [LANES-1:0] lane_ok;

  for (genvar li = 0; li < LANES; li++) begin : g_lane
    logic same;
    assign same        = (data[8*li +: 8] == ref_data[8*li +: 8]);
    assign lane_ok[li] = ~lane_en[li] | same;
  end

  logic all_ok;
  assign all_ok = &lane_ok;
  assign hit    = neq ? ~all_ok : all_ok;

endmodule

// File: rtl/lsw_event_ctrl.sv
module lsw_event_ctrl #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          match,
  input  logic          retire,
  input  logic          flush,
  input  logic          cnt_load,
  input  logic [CW-1:0] cnt_init,
  output logic          evt,
  output logic [CW-1:0] cnt,
  output logic          cnt_zero
);

  logic          pend_q, pend_d;
  logic          evt_q, evt_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          fire;

  // next-state
  always_comb begin
    fire   = retire & ~flush & (pend_q | match);
    evt_d  = fire;
    pend_d = (retire | flush) ? 1'b0 : (pend_q | match);
    cnt_en = cnt_load | (fire & (|cnt_q));
    cnt_d  = cnt_load ? cnt_init : (cnt_q - {{(CW-1){1'b0}}, 1'b1});
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      evt_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      pend_q <= pend_d;
      evt_q  <= evt_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign evt      = evt_q;
  assign cnt      = cnt_q;
  assign cnt_zero = (cnt_q == '0);

endmodule

// File: rtl/lsw_data_watch.sv
module lsw_data_watch
  import lsw_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int CW = 16,
  localparam int LANES = DW / 8,
  localparam int NCMP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic [1:0]       acc_size,
  input  logic             acc_write,
  input  logic [DW-1:0]    acc_data,
  input  logic             instr_retire,
  input  logic             flush,
  input  logic [AW-1:0]    cmp_addr_a,
  input  logic [AW-1:0]    cmp_addr_b,
  input  logic [1:0]       addr_op_a,
  input  logic [1:0]       addr_op_b,
  input  logic             range_en,
  input  logic [DW-1:0]    cmp_data,
  input  logic [LANES-1:0] lane_en,
  input  logic             data_neq,
  input  logic [1:0]       dir_sel,
  input  logic             cnt_load,
  input  logic [CW-1:0]    cnt_init,
  output logic             wp_event,
  output logic [CW-1:0]    cnt_value,
  output logic             cnt_zero
);

  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  // address comparators
  logic [AW-1:0]   ref_addr [NCMP];
  logic [1:0]      ref_op   [NCMP];
  logic [NCMP-1:0] addr_hit;

  assign ref_addr[0] = cmp_addr_a;
  assign ref_addr[1] = cmp_addr_b;
  assign ref_op[0]   = addr_op_a;
  assign ref_op[1]   = addr_op_b;

  for (genvar ci = 0; ci < NCMP; ci++) begin : g_acmp
    lsw_addr_cmp #(.AW(AW)) u_acmp (
      .addr     (acc_addr),
      .size     (acc_size),
      .ref_addr (ref_addr[ci]),
      .op       (ref_op[ci]),
      .hit      (addr_hit[ci])
    );
  end

  logic addr_ok;
  assign addr_ok = range_en ? (&addr_hit) : addr_hit[0];

  // data comparator
  logic data_ok;
  lsw_data_cmp #(.DW(DW)) u_dcmp (
    .data     (acc_data),
    .ref_data (cmp_data),
    .lane_en  (lane_en),
    .neq      (data_neq),
    .hit      (data_ok)
  );

  // direction qualifier
  logic dir_ok;
  always_comb begin
    case (dir_sel_e'(dir_sel))
      DIR_ANY:   dir_ok = 1'b1;
      DIR_READ:  dir_ok = ~acc_write;
      DIR_WRITE: dir_ok = acc_write;
      default:   dir_ok = 1'b0;
    endcase
  end

  logic match;
  assign match = acc_valid & dir_ok & addr_ok & data_ok;

  lsw_event_ctrl #(.CW(CW)) u_evt (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .match    (match),
    .retire   (instr_retire),
    .flush    (flush),
    .cnt_load (cnt_load),
    .cnt_init (cnt_init),
    .evt      (wp_event),
    .cnt      (cnt_value),
    .cnt_zero (cnt_zero)
  );

endmodule

// File: rtl/lsw_data_watch_chk.sv
module lsw_data_watch_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          instr_retire,
  input logic          flush,
  input logic          cnt_load,
  input logic          wp_event,
  input logic [CW-1:0] cnt_value,
  input logic          cnt_zero
);

  AST_EVT_AFTER_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
    wp_event |-> ($past(instr_retire) && !$past(flush))); // R7

  AST_FLUSH_NO_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !wp_event); // R8

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wp_event && !$past(cnt_load) && ($past(cnt_value) != '0))
      |-> (cnt_value == $past(cnt_value) - 1'b1)); // R9

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wp_event && !$past(cnt_load)) |-> (cnt_value == $past(cnt_value))); // R9

  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_zero && !cnt_load) |=> cnt_zero); // R10

endmodule

bind lsw_data_watch lsw_data_watch_chk #(.CW(CW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .instr_retire (instr_retire),
  .flush        (flush),
  .cnt_load     (cnt_load),
  .wp_event     (wp_event),
  .cnt_value    (cnt_value),
  .cnt_zero     (cnt_zero)
);

// File: tb/lsw_data_watch_tb.sv
module lsw_data_watch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int CW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acc_valid = 1'b0;
  logic [AW-1:0] acc_addr = '0;
  logic [1:0]    acc_size = 2'b10;
  logic          acc_write = 1'b0;
  logic [DW-1:0] acc_data = '0;
  logic          instr_retire = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] cmp_addr_a = '0;
  logic [AW-1:0] cmp_addr_b = '0;
  logic [1:0]    addr_op_a = 2'd0;
  logic [1:0]    addr_op_b = 2'd0;
  logic          range_en = 1'b0;
  logic [DW-1:0] cmp_data = '0;
  logic [3:0]    lane_en = 4'b0000;
  logic          data_neq = 1'b0;
  logic [1:0]    dir_sel = 2'd0;
  logic          cnt_load = 1'b0;
  logic [CW-1:0] cnt_init = '0;
  logic          wp_event;
  logic [CW-1:0] cnt_value;
  logic          cnt_zero;

  int    n_chk = 0;
  int    n_err = 0;
  string cur_req = "R1";
  bit    cmp_on = 1'b0;
  bit    done = 1'b0;

  lsw_data_watch #(.AW(AW), .DW(DW), .CW(CW)) u_dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  function automatic bit ref_addr_ok(input logic [31:0] a, input logic [1:0] sz,
                                     input logic [31:0] r, input logic [1:0] op);
    longint unsigned g, qa, qr;
    g  = (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
    qa = longint'(a) / g;
    qr = longint'(r) / g;
    case (op)
      2'd0: return qa == qr;
      2'd1: return qa != qr;
      2'd2: return qa >= qr;
      default: return qa < qr;
    endcase
  endfunction

  function automatic bit ref_match();
    bit a_ok, d_all, dir_ok;
    if (!acc_valid) return 0;
    case (dir_sel)
      2'd0: dir_ok = 1;
      2'd1: dir_ok = !acc_write;
      2'd2: dir_ok = acc_write;
      default: dir_ok = 0;
    endcase
    a_ok = ref_addr_ok(acc_addr, acc_size, cmp_addr_a, addr_op_a);
    if (range_en) a_ok = a_ok && ref_addr_ok(acc_addr, acc_size, cmp_addr_b, addr_op_b);
    d_all = 1;
    for (int i = 0; i < 4; i++)
      if (lane_en[i] && ((acc_data >> (8*i)) & 32'hFF) != ((cmp_data >> (8*i)) & 32'hFF))
        d_all = 0;
    return dir_ok && a_ok && (data_neq ? !d_all : d_all);
  endfunction

  bit m_pend, m_evt;
  int m_cnt;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 0; m_evt <= 0; m_cnt <= 0;
    end else begin
      bit hit, fire;
      hit  = ref_match();
      fire = instr_retire && !flush && (m_pend || hit);
      m_evt  <= fire;
      m_pend <= (instr_retire || flush) ? 1'b0 : (m_pend || hit);
      if (cnt_load) m_cnt <= cnt_init;
      else if (fire && m_cnt > 0) m_cnt <= m_cnt - 1;
    end
  end

  always @(negedge clk) begin
    if (cmp_on && !done) begin
      n_chk++;
      if (wp_event !== m_evt || int'(cnt_value) != m_cnt || cnt_zero !== (m_cnt == 0)) begin
        n_err++;
        $display("FAIL %s model: evt=%0b cnt=%0d zero=%0b expected evt=%0b cnt=%0d zero=%0b",
                 cur_req, wp_event, cnt_value, cnt_zero, m_evt, m_cnt, (m_cnt == 0));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic xfer(input logic [31:0] a, input logic [1:0] sz, input logic wr,
                      input logic [31:0] d, input logic ret, input logic fl);
    acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr; acc_data = d;
    instr_retire = ret; flush = fl;
    @(negedge clk);
    acc_valid = 1'b0; instr_retire = 1'b0; flush = 1'b0;
  endtask

  task automatic idle(input logic ret, input logic fl);
    acc_valid = 1'b0; instr_retire = ret; flush = fl;
    @(negedge clk);
    instr_retire = 1'b0; flush = 1'b0;
  endtask

  task automatic load_cnt(input int v);
    cnt_load = 1'b1; cnt_init = CW'(v);
    @(negedge clk);
    cnt_load = 1'b0;
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    cur_req = "R1";
    chk("R1", "wp_event", wp_event, 0);
    chk("R1", "cnt_value", cnt_value, 0);
    chk("R1", "cnt_zero", cnt_zero, 1);
    cmp_on = 1'b1;

    cur_req = "R9";
    load_cnt(10);
    chk("R9", "load", cnt_value, 10);
    chk("R9", "zero after load", cnt_zero, 0);

    cmp_addr_a = 32'h2002; addr_op_a = 2'd0; range_en = 0;
    cmp_data = 32'h00AB_0000; lane_en = 4'b0100; data_neq = 0; dir_sel = 2'd0;

    cur_req = "R2";
    xfer(32'h2000, 2'b10, 0, 32'h11AB_2233, 1, 0);
    chk("R2", "word ignores low bits", wp_event, 1);
    chk("R9", "decrement", cnt_value, 9);

    cur_req = "R3";
    xfer(32'h2003, 2'b01, 0, 32'h11AB_2233, 1, 0);
    chk("R3", "half ignores bit0", wp_event, 1);
    xfer(32'h2003, 2'b00, 0, 32'h11AB_2233, 1, 0);
    chk("R3", "byte compares all bits", wp_event, 0);
    chk("R3", "cnt held", cnt_value, 8);

    cur_req = "R7";
    xfer(32'h2000, 2'b10, 0, 32'h00AB_0000, 0, 0);
    chk("R7", "no event before retire", wp_event, 0);
    xfer(32'h2002, 2'b01, 0, 32'h00AB_0000, 0, 0);
    xfer(32'h2002, 2'b00, 0, 32'h00AB_0000, 0, 0);
    chk("R7", "still none", wp_event, 0);
    idle(1, 0);
    chk("R7", "one event on retire", wp_event, 1);
    chk("R7", "one decrement", cnt_value, 7);
    idle(0, 0);
    chk("R7", "single pulse", wp_event, 0);

    cur_req = "R8";
    xfer(32'h2000, 2'b10, 0, 32'h00AB_0000, 0, 0);
    idle(0, 1);
    idle(1, 0);
    chk("R8", "flush drops match", wp_event, 0);
    xfer(32'h2000, 2'b10, 0, 32'h00AB_0000, 1, 1);
    chk("R8", "flush at retire", wp_event, 0);
    chk("R8", "cnt unchanged", cnt_value, 7);

    cur_req = "R6";
    dir_sel = 2'd2;
    xfer(32'h2000, 2'b10, 0, 32'h00AB_0000, 1, 0);
    chk("R6", "read blocked", wp_event, 0);
    xfer(32'h2000, 2'b10, 1, 32'h00AB_0000, 1, 0);
    chk("R6", "write passes", wp_event, 1);
    dir_sel = 2'd3;
    xfer(32'h2000, 2'b10, 1, 32'h00AB_0000, 1, 0);
    chk("R6", "off blocks all", wp_event, 0);
    dir_sel = 2'd0;

    cur_req = "R5";
    data_neq = 1;
    xfer(32'h2000, 2'b10, 0, 32'h11AB_2233, 1, 0);
    chk("R5", "ne same lane", wp_event, 0);
    xfer(32'h2000, 2'b10, 0, 32'h00CD_0000, 1, 0);
    chk("R5", "ne differs", wp_event, 1);
    data_neq = 0; lane_en = 4'b0000;
    xfer(32'h2000, 2'b10, 0, 32'hDEAD_BEEF, 1, 0);
    chk("R5", "all lanes off", wp_event, 1);
    lane_en = 4'b0011; cmp_data = 32'h0000_BEEF;
    xfer(32'h2000, 2'b10, 0, 32'hDEAD_BEEF, 1, 0);
    chk("R5", "half lane match", wp_event, 1);
    chk("R9", "cnt", cnt_value, 3);
    lane_en = 4'b0000;

    cur_req = "R4";
    load_cnt(20);
    cmp_addr_a = 32'h3000; addr_op_a = 2'd2;
    cmp_addr_b = 32'h3010; addr_op_b = 2'd3; range_en = 1;
    xfer(32'h300C, 2'b10, 0, 0, 1, 0);
    chk("R4", "inside range", wp_event, 1);
    xfer(32'h3010, 2'b10, 0, 0, 1, 0);
    chk("R4", "upper bound", wp_event, 0);
    xfer(32'h2FFC, 2'b10, 0, 0, 1, 0);
    chk("R4", "below range", wp_event, 0);
    range_en = 0; cmp_addr_a = 32'h4000; addr_op_a = 2'd1;
    xfer(32'h4000, 2'b10, 0, 0, 1, 0);
    chk("R4", "ne equal addr", wp_event, 0);
    xfer(32'h4004, 2'b10, 0, 0, 1, 0);
    chk("R4", "ne other addr", wp_event, 1);

    cur_req = "R11";
    xfer(32'h4002, 2'b11, 0, 0, 1, 0);
    chk("R11", "reserved size as word", wp_event, 0);
    xfer(32'h4002, 2'b01, 0, 0, 1, 0);
    chk("R11", "half contrast", wp_event, 1);

    cur_req = "R10";
    addr_op_a = 2'd1;
    load_cnt(1);
    xfer(32'h4004, 2'b10, 0, 0, 1, 0);
    chk("R10", "reach zero", cnt_value, 0);
    chk("R10", "flag", cnt_zero, 1);
    xfer(32'h4004, 2'b10, 0, 0, 1, 0);
    chk("R10", "saturate", cnt_value, 0);
    cnt_load = 1; cnt_init = 6'd5;
    xfer(32'h4004, 2'b10, 0, 0, 1, 0);
    cnt_load = 0;
    chk("R10", "load wins", cnt_value, 5);

    cur_req = "R7";
    for (int k = 0; k < 4000; k++) begin
      if (k % 500 == 0) begin
        cmp_addr_a = 32'h5000 + ($urandom % 16);
        cmp_addr_b = 32'h5008 + ($urandom % 16);
        addr_op_a  = 2'($urandom); addr_op_b = 2'($urandom);
        range_en   = 1'($urandom); lane_en = 4'($urandom);
        data_neq   = 1'($urandom); dir_sel = 2'($urandom % 3);
        cmp_data   = {4{8'($urandom % 4)}};
      end
      acc_valid    = 1'($urandom);
      acc_addr     = 32'h5000 + ($urandom % 32);
      acc_size     = 2'($urandom);
      acc_write    = 1'($urandom);
      acc_data     = {8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4), 8'($urandom % 4)};
      instr_retire = ($urandom % 4) == 0;
      flush        = ($urandom % 20) == 0;
      cnt_load     = ($urandom % 60) == 0;
      cnt_init     = CW'($urandom % 8);
      @(negedge clk);
    end
    acc_valid = 0; instr_retire = 0; flush = 0; cnt_load = 0;
    @(negedge clk);
    finish_run();
  end

endmodule